// File: doc/BRIEF.md
# RTC Alarm Comparator with Open-Drain Interrupt

This block watches a running calendar clock and raises an alarm when the time reaches a programmed moment. Five alarm registers hold a BCD month, date, hour, minute and second. A five-bit repeat code is spread over their spare bits and selects which of these fields must agree with the clock. Once per second, on a tick from the time counters, the block compares the selected fields. On agreement it sets a sticky alarm flag. Software clears the flag by reading the flags register.

The interrupt output is a pull-low enable for an open-drain pin with an external pull-up. When the output is 1 the pad drives the pin low. When it is 0 the pin is released, so the block never drives the pin high. A host walks the registers through an address pointer. If the pointer is on the flags register when an alarm fires, the interrupt waits until the pointer leaves that address. The flag itself is still set.

The bus is a plain strobe interface. A write or read acts in the cycle its strobe is high, at the address on `bus_ptr`. Read data is combinational from the pointer. There is no stream traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_alarm_unit`

## Requirements
- R1: The alarm slots at addresses 0x0A (month), 0x0B (date), 0x0C (hour), 0x0D (minute) and 0x0E (second) store whole bytes on write, and `bus_rdata` returns the stored byte while the pointer is on them. The slot fields are laid out as follows. Slot 0x0A: bit7 = interrupt enable, bit6 = square-wave enable, bit5 = RPT5, bits4:0 = month. Slot 0x0B: bit7 = RPT4, bits5:0 = date. Slot 0x0C: bit7 = RPT3, bits5:0 = hour. Slot 0x0D: bit7 = RPT2, bits6:0 = minute. Slot 0x0E: bit7 = RPT1, bits6:0 = second.
- R2: The repeat code {RPT5..RPT1} selects the fields that must match, as follows. 00000 selects month, date, hour, minute and second. 10000 selects date, hour, minute and second. 11000 selects hour, minute and second. 11100 selects minute and second. 11110 selects second only. 11111 selects no field, so the alarm fires every tick. Unselected fields do not affect the result.
- R3: Any repeat code not listed in R2 makes the alarm fire on every seconds tick, whatever the time is.
- R4: The match is taken only in a cycle where `sec_tick` is 1. The flag rises at the clock edge that samples that tick, and never rises without a tick.
- R5: The alarm flag stays set until a read strobe occurs with the pointer at 0x0F. The flag is visible as bit 6 of the byte read at 0x0F, and it is 0 from the edge that ends that read.
- R6: If an alarm fires in the same cycle as a clearing read, the flag stays set.
- R7: `irq_pull_low` is 1 only while all of the following hold: the flag is set, the interrupt enable is 1, the square-wave enable is 0, and the alarm is not held back (R8). The interrupt releases on the read that clears the flag.
- R8: An alarm that fires while the pointer is at 0x0F sets the flag but keeps `irq_pull_low` at 0. The interrupt is released to the pin from the first edge at which the pointer is at a different address.
- R9: Writes to 0x0F or to any unmapped address change no state. Reads at unmapped addresses return 0.
- R10: A synchronous active-high reset clears the flag and every alarm slot, and leaves the interrupt released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| now_month | input | 5 | Current month, BCD |
| bus_ptr | input | 8 | Register address pointer |
| bus_wr | input | 1 | Write strobe at `bus_ptr` |
| bus_rd | input | 1 | Read strobe at `bus_ptr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_ptr` |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt pin low |

## Verification
The bench uses the default parameters: alarm base 0x0A, flags address 0x0F, flag bit 6 and an 8-bit pointer. With these values the flags register sits directly after the last alarm slot. A pointer that steps past the seconds slot therefore lands on the flags address, and the hold-back path is reached with ordinary register traffic. The five narrow BCD widths keep single-bit field disturbances small. This lets random trials reach both the case where one selected field differs and the case where only unselected fields differ, for every repeat code, including the undefined ones.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int DATA_W = 8;
  localparam int NSLOT  = 5;

  // slot order follows the address order: month, date, hour, minute, second
  localparam int S_MONTH = 0;
  localparam int S_DATE  = 1;
  localparam int S_HOUR  = 2;
  localparam int S_MIN   = 3;
  localparam int S_SEC   = 4;

  typedef enum logic [2:0] {
    RM_YEARLY,
    RM_MONTHLY,
    RM_DAILY,
    RM_HOURLY,
    RM_MINUTELY,
    RM_SECONDLY
  } rpt_mode_e;

  typedef struct packed {
    logic       afe;
    logic       sqwe;
    logic [4:0] rpt;
  } alarm_ctrl_t;

  // BCD value bits compared for each slot
  function automatic logic [DATA_W-1:0] slot_mask(input int s);
    case (s)
      S_MONTH: slot_mask = 8'h1F;
      S_DATE:  slot_mask = 8'h3F;
      S_HOUR:  slot_mask = 8'h3F;
      default: slot_mask = 8'h7F;
    endcase
  endfunction

  // undefined codes fall back to the every-second behaviour
  function automatic rpt_mode_e decode_rpt(input logic [4:0] code);
    case (code)
      5'b00000: decode_rpt = RM_YEARLY;
      5'b10000: decode_rpt = RM_MONTHLY;
      5'b11000: decode_rpt = RM_DAILY;
      5'b11100: decode_rpt = RM_HOURLY;
      5'b11110: decode_rpt = RM_MINUTELY;
      default:  decode_rpt = RM_SECONDLY;
    endcase
  endfunction

  // bit s set = slot s must agree with the clock
  function automatic logic [NSLOT-1:0] slots_used(input rpt_mode_e m);
    case (m)
      RM_YEARLY:   slots_used = 5'b11111;
      RM_MONTHLY:  slots_used = 5'b11110;
      RM_DAILY:    slots_used = 5'b11100;
      RM_HOURLY:   slots_used = 5'b11000;
      RM_MINUTELY: slots_used = 5'b10000;
      default:     slots_used = 5'b00000;
    endcase
  endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h0A,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'h0F,
  parameter int                AF_BIT     = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           ptr,
  input  logic                        wr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        af,
  output logic [DATA_W-1:0]           rdata,
  output logic [NSLOT-1:0][DATA_W-1:0] alarm_q,
  output alarm_ctrl_t                 ctrl
);

  logic [NSLOT-1:0] sel;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign sel[s] = (ptr == BASE_ADDR + ADDR_W'(s));

      always_ff @(posedge clk) begin
        if (rst)
          alarm_q[s] <= '0;
        else if (wr && sel[s])
          alarm_q[s] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSLOT; s++)
      if (sel[s]) rdata = alarm_q[s];
    if (ptr == FLAGS_ADDR) rdata[AF_BIT] = af;
  end

  // control bits gathered from the spare bits of the slots
  assign ctrl.afe  = alarm_q[S_MONTH][7];
  assign ctrl.sqwe = alarm_q[S_MONTH][6];
  assign ctrl.rpt  = {alarm_q[S_MONTH][5], alarm_q[S_DATE][7],
                      alarm_q[S_HOUR][7], alarm_q[S_MIN][7],
                      alarm_q[S_SEC][7]};

  // R9: writes outside the alarm slots leave the slots untouched
  p_stray_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && (sel == '0)) |=> $stable(alarm_q));

  // R1: a write to a slot is read back on the next cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    (wr && sel[S_SEC]) |=> (alarm_q[S_SEC] == $past(wdata)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [NSLOT-1:0][DATA_W-1:0] alarm_q,
  input  logic [NSLOT-1:0][DATA_W-1:0] now_q,
  input  logic [4:0]                   rpt,
  output rpt_mode_e                    mode,
  output logic                         hit
);

  logic [NSLOT-1:0] agree;
  logic [NSLOT-1:0] used;

  assign mode = decode_rpt(rpt);
  assign used = slots_used(mode);

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
      assign agree[s] = ((alarm_q[s] ^ now_q[s]) & slot_mask(s)) == '0;
    end
  endgenerate

  assign hit = &(agree | ~used);

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic flag_rd,
  input  logic ptr_on_flags,
  input  logic afe,
  input  logic sqwe,
  output logic af,
  output logic irq_pull
);

  logic evt;
  logic held;

  assign evt = tick && hit;

  // a fresh alarm wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          af <= 1'b0;
    else if (evt)     af <= 1'b1;
    else if (flag_rd) af <= 1'b0;
  end

  // hold the interrupt back while the pointer parks on the flags address
  always_ff @(posedge clk) begin
    if (rst)                              held <= 1'b0;
    else if (!ptr_on_flags)               held <= 1'b0;
    else if (evt && (!af || flag_rd))     held <= 1'b1;
  end

  assign irq_pull = af && afe && !sqwe && !held;

  p_af_set_r4: assert property (@(posedge clk) disable iff (rst)
    evt |=> af);

  p_no_tick_no_set_r4: assert property (@(posedge clk) disable iff (rst)
    (!af && !evt) |=> !af);

  p_af_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (af && !flag_rd) |=> af);

  p_af_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !evt) |=> !af);

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && evt) |=> af);

  p_hold_back_r8: assert property (@(posedge clk) disable iff (rst)
    (ptr_on_flags && evt && !af) |=> !irq_pull);

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h0A,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'h0F,
  parameter int                AF_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic [5:0]        now_date,
  input  logic [4:0]        now_month,
  input  logic [ADDR_W-1:0] bus_ptr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              alarm_flag,
  output logic              irq_pull_low
);

  logic [NSLOT-1:0][DATA_W-1:0] alarm_q;
  logic [NSLOT-1:0][DATA_W-1:0] now_q;
  alarm_ctrl_t                  ctrl;
  rpt_mode_e                    mode;
  logic                         hit;
  logic                         ptr_on_flags;
  logic                         flag_rd;

  assign now_q[S_MONTH] = DATA_W'(now_month);
  assign now_q[S_DATE]  = DATA_W'(now_date);
  assign now_q[S_HOUR]  = DATA_W'(now_hour);
  assign now_q[S_MIN]   = DATA_W'(now_min);
  assign now_q[S_SEC]   = DATA_W'(now_sec);

  assign ptr_on_flags = (bus_ptr == FLAGS_ADDR);
  assign flag_rd      = bus_rd && ptr_on_flags;

  rtc_alarm_regs #(
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .FLAGS_ADDR (FLAGS_ADDR),
    .AF_BIT     (AF_BIT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ptr     (bus_ptr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .af      (alarm_flag),
    .rdata   (bus_rdata),
    .alarm_q (alarm_q),
    .ctrl    (ctrl)
  );

  rtc_alarm_match u_match (
    .alarm_q (alarm_q),
    .now_q   (now_q),
    .rpt     (ctrl.rpt),
    .mode    (mode),
    .hit     (hit)
  );

  rtc_alarm_irq u_irq (
    .clk          (clk),
    .rst          (rst),
    .tick         (sec_tick),
    .hit          (hit),
    .flag_rd      (flag_rd),
    .ptr_on_flags (ptr_on_flags),
    .afe          (ctrl.afe),
    .sqwe         (ctrl.sqwe),
    .af           (alarm_flag),
    .irq_pull     (irq_pull_low)
  );

  // R3: the fallback mode matches at any time
  p_every_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_SECONDLY) |-> hit);

  // R7: the square-wave enable and a cleared enable both keep the pin released
  p_sqwe_masks_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.sqwe |-> !irq_pull_low);

  p_afe_gates_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.afe |-> !irq_pull_low);

  // R5: a clearing read releases the interrupt on the next cycle
  p_read_releases_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !(sec_tick && hit)) |=> !irq_pull_low);

endmodule

// File: tb/test_rtc_alarm_unit.sv
module test_rtc_alarm_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [6:0] now_sec = '0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [5:0] now_date = '0;
  logic [4:0] now_month = '0;
  logic [7:0] bus_ptr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       alarm_flag;
  logic       irq_pull_low;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] FL = 8'h0F;

  always #5 clk = ~clk;

  rtc_alarm_unit i_rtc_alarm_unit (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_month(now_month),
    .bus_ptr(bus_ptr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_flag(alarm_flag), .irq_pull_low(irq_pull_low)
  );

  logic [7:0] alm [5];
  logic [7:0] nowv [5];

  function automatic logic [7:0] mask_of(input int s);
    case (s)
      0: return 8'h1F;
      1, 2: return 8'h3F;
      default: return 8'h7F;
    endcase
  endfunction

  function automatic int width_of(input int s);
    case (s)
      0: return 5;
      1, 2: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [4:0] used_of(input logic [4:0] c);
    case (c)
      5'b00000: return 5'b11111;
      5'b10000: return 5'b11110;
      5'b11000: return 5'b11100;
      5'b11100: return 5'b11000;
      5'b11110: return 5'b10000;
      default:  return 5'b00000;
    endcase
  endfunction

  function automatic bit exp_hit(input logic [4:0] c);
    logic [4:0] u = used_of(c);
    for (int s = 0; s < 5; s++)
      if (u[s] && (((alm[s] ^ nowv[s]) & mask_of(s)) != 0)) return 0;
    return 1;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_ptr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    bus_ptr = a; #1; v = bus_rdata;
  endtask

  task automatic rd_flags(output logic [7:0] v);
    bus_ptr = FL; bus_rd = 1'b1; #1; v = bus_rdata;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic drive_now();
    now_month = nowv[0][4:0]; now_date = nowv[1][5:0]; now_hour = nowv[2][5:0];
    now_min = nowv[3][6:0]; now_sec = nowv[4][6:0];
  endtask

  task automatic load_alarm(input logic afe, input logic sqwe, input logic [4:0] c);
    alm[0] = {afe, sqwe, c[4], alm[0][4:0]};
    alm[1][7] = c[3]; alm[2][7] = c[2]; alm[3][7] = c[1]; alm[4][7] = c[0];
    for (int s = 0; s < 5; s++) wr(8'h0A + 8'(s), alm[s]);
    bus_ptr = 8'h00;
  endtask

  task automatic tick_once();
    sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [4:0] code;
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED);
    #1;
    cyc(); cyc(); cyc();
    rst = 1'b0;

    // R10: reset state
    chk(alarm_flag == 0, "R10 flag", alarm_flag, 0);
    chk(irq_pull_low == 0, "R10 irq", irq_pull_low, 0);
    for (int s = 0; s < 5; s++) begin
      peek(8'h0A + 8'(s), v);
      chk(v == 0, "R10 slot", v, 0);
    end

    // R1: readback
    for (int s = 0; s < 5; s++) begin
      wr(8'h0A + 8'(s), 8'hA0 + 8'(s * 3));
      peek(8'h0A + 8'(s), v);
      chk(v == 8'hA0 + 8'(s * 3), "R1 readback", v, 8'hA0 + s * 3);
    end

    // R4: matching time but no tick
    for (int s = 0; s < 5; s++) alm[s] = 8'h00;
    alm[0][4:0] = 5'h12; alm[1][5:0] = 6'h25; alm[2][5:0] = 6'h09;
    alm[3][6:0] = 7'h30; alm[4][6:0] = 7'h45;
    for (int s = 0; s < 5; s++) nowv[s] = alm[s] & mask_of(s);
    load_alarm(1'b1, 1'b0, 5'b00000);
    drive_now();
    cyc(); cyc(); cyc();
    chk(alarm_flag == 0, "R4 no tick", alarm_flag, 0);
    tick_once();
    chk(alarm_flag == 1, "R4 tick sets", alarm_flag, 1);
    chk(irq_pull_low == 1, "R7 irq on", irq_pull_low, 1);

    // R6: alarm and clearing read in one cycle
    bus_ptr = FL; bus_rd = 1'b1; sec_tick = 1'b1;
    cyc();
    bus_rd = 1'b0; sec_tick = 1'b0;
    chk(alarm_flag == 1, "R6 set wins", alarm_flag, 1);
    rd_flags(v);
    chk(v[6] == 1, "R5 flag bit", v, 8'h40);
    chk(alarm_flag == 0, "R5 cleared", alarm_flag, 0);
    chk(irq_pull_low == 0, "R7 release on read", irq_pull_low, 0);

    // R8: alarm while pointer sits on flags
    bus_ptr = FL;
    tick_once();
    chk(alarm_flag == 1, "R8 flag set", alarm_flag, 1);
    chk(irq_pull_low == 0, "R8 held", irq_pull_low, 0);
    cyc(); cyc();
    chk(irq_pull_low == 0, "R8 still held", irq_pull_low, 0);
    bus_ptr = 8'h03;
    cyc();
    chk(irq_pull_low == 1, "R8 released", irq_pull_low, 1);
    rd_flags(v);
    chk(irq_pull_low == 0 && alarm_flag == 0, "R5 read clears", alarm_flag, 0);

    // R9: stray writes
    wr(FL, 8'hFF);
    peek(FL, v);
    chk(v == 0, "R9 flags write", v, 0);
    wr(8'h10, 8'h5A);
    peek(8'h10, v);
    chk(v == 0, "R9 unmapped read", v, 0);
    peek(8'h0E, v);
    chk(v == alm[4], "R9 slots kept", v, alm[4]);

    // R3: undefined code fires at a mismatching time
    nowv[4] = 7'h01; drive_now();
    load_alarm(1'b1, 1'b0, 5'b01010);
    tick_once();
    chk(alarm_flag == 1, "R3 undefined code", alarm_flag, 1);
    rd_flags(v);

    // R2/R3/R7: random trials
    for (int it = 0; it < 400; it++) begin
      logic afe, sqwe;
      bit e;
      case ($urandom % 8)
        0: code = 5'b00000;
        1: code = 5'b10000;
        2: code = 5'b11000;
        3: code = 5'b11100;
        4: code = 5'b11110;
        5: code = 5'b11111;
        default: code = 5'($urandom);
      endcase
      for (int s = 0; s < 5; s++) begin
        alm[s] = 8'($urandom);
        nowv[s] = alm[s] & mask_of(s);
      end
      if ($urandom % 2) begin
        int k = $urandom % 5;
        nowv[k] = nowv[k] ^ (8'd1 << ($urandom % width_of(k)));
      end
      afe = 1'($urandom); sqwe = 1'($urandom);
      load_alarm(afe, sqwe, code);
      drive_now();
      e = exp_hit(code);
      tick_once();
      chk(alarm_flag == e, "R2 match", alarm_flag, e);
      chk(irq_pull_low == (e && afe && !sqwe), "R7 gate", irq_pull_low, e && afe && !sqwe);
      rd_flags(v);
      chk(v[6] == e, "R5 flag read", v[6], e);
      chk(alarm_flag == 0, "R5 after read", alarm_flag, 0);
    end

    // R10: reset mid-run
    tick_once();
    rst = 1'b1; cyc(); rst = 1'b0;
    chk(alarm_flag == 0 && irq_pull_low == 0, "R10 rerun", alarm_flag, 0);
    peek(8'h0A, v);
    chk(v == 0, "R10 slot cleared", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule